// File: doc/BRIEF.md
# Weighted Switching-Activity Counter

This block gives a rough, technology-independent estimate of dynamic power. It watches several equal-width register words. Each cycle it receives each word's present value, the value the word is about to take, and a strobe that says whether the word is being updated. From these it counts the bit transitions.

Every transition is scaled by a programmable weight chosen by its bit position. The scaled counts of all contributing words are added together. That sum is shown one cycle later as the activity of that cycle, and it is also added into a running total. The running total saturates at its largest value.

A mode input chooses between two ways of counting. In the first mode every flipped bit counts. In the second mode only bits that go from 0 to 1 count. A mask picks which words contribute.

The running total is kept by a two-state accumulator machine:

- **ACC_RUN**: the total adds the cycle sum.
- **ACC_FULL**: the total is held at its maximum.

Transitions between the states:

- **ACC_RUN → ACC_FULL**: taken when an addition reaches or exceeds the maximum.
- **ACC_FULL → ACC_RUN**: taken on a synchronous clear.
- **ACC_RUN → ACC_RUN**: taken on clear, and on any addition that stays below the maximum.

Top module: `tgl_activity_meter`

## Requirements
- R1: With `up_mode`=0 (any-edge), word w (bits [w*WIDTH +: WIDTH] of `cur_bus`/`nxt_bus`) contributes the sum of weight[i] over every bit i where the present and next values differ.
- R2: With `up_mode`=1 (rising-only), a bit i counts only when its present value is 0 and its next value is 1. A bit going from 1 to 0 adds nothing.
- R3: Weight i (bit position i, with index 0 being the LSB) is an 8-bit unsigned value. It is written from `wgt_val` when `wgt_we`=1 and `wgt_idx`=i. The new value is used from the following cycle; a count made in the same cycle as the write uses the old weight.
- R4: After reset, every weight is 1, and `cyc_act` and `run_total` are both 0.
- R5: When `incl_mask` is all zeros, every word may contribute. When any bit of `incl_mask` is set, only the words whose own bit w is set contribute.
- R6: A word whose `upd_vld[w]` is 0 contributes nothing in that cycle.
- R7: One cycle after the inputs are presented, `cyc_act` equals the weighted sum for that cycle. `run_total` advances by the same sum at the same edge.
- R8: `run_total` saturates at 2^TOTAL_W-1 and stays there, whatever the later activity, until it is cleared.
- R9: When `clr`=1, the next edge sets both `cyc_act` and `run_total` to 0 and discards that cycle's activity. Clear leaves the weights unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the cycle count and the running total |
| up_mode | input | 1 | 0 = count every edge, 1 = count rising edges only |
| incl_mask | input | NWORDS | Per-word include bits; all zeros means every word may contribute |
| upd_vld | input | NWORDS | Per-word update strobe |
| cur_bus | input | NWORDS*WIDTH | Present values, word w at [w*WIDTH +: WIDTH] |
| nxt_bus | input | NWORDS*WIDTH | Next values, same layout as `cur_bus` |
| wgt_we | input | 1 | Weight write enable |
| wgt_idx | input | IDX_W | Bit position of the weight being written |
| wgt_val | input | WGT_W | Weight value to write |
| cyc_act | output | SUM_W | Weighted activity of the previous cycle |
| run_total | output | TOTAL_W | Saturating accumulated activity |

## Verification
A weight write can happen in the same cycle as a count that uses that same bit position. The bench provokes this by writing a new weight for a bit that is toggling in that very cycle. It expects the count of that cycle to use the old weight, and the count of the next cycle to use the new one.

A clear can also coincide with heavy activity, and a clear can arrive while the total is saturated. The bench judges this by expecting zeros on both outputs, and then a restart from zero.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_mode_e;

    typedef enum logic {
        ACC_RUN  = 1'b0,
        ACC_FULL = 1'b1
    } acc_state_e;
endpackage

// File: rtl/tgl_weight_bank.sv
module tgl_weight_bank #(
    parameter int WIDTH = 16,
    parameter int WGT_W = 8,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [WGT_W-1:0]       wr_val,
    output logic [WIDTH*WGT_W-1:0] wgt_flat
);
    localparam logic [WGT_W-1:0] WGT_RESET = WGT_W'(1);

    for (genvar i = 0; i < WIDTH; i++) begin : g_wgt
        logic [WGT_W-1:0] w_q;
        logic             hit;

        assign hit = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= WGT_RESET;
            end else if (hit) begin
                w_q <= wr_val;
            end
        end

        assign wgt_flat[i*WGT_W +: WGT_W] = w_q;

        // R3
        wgt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i)) |=> (wgt_flat[i*WGT_W +: WGT_W] == $past(wr_val)));

        // R3
        wgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(wgt_flat[i*WGT_W +: WGT_W]));
    end
endmodule

// File: rtl/tgl_word_sum.sv
module tgl_word_sum #(
    parameter int WIDTH  = 16,
    parameter int WGT_W  = 8,
    parameter int WSUM_W = 12
) (
    input  logic [WIDTH-1:0]       cur,
    input  logic [WIDTH-1:0]       nxt,
    input  logic                   rise_only,
    input  logic                   en,
    input  logic [WIDTH*WGT_W-1:0] wgt_flat,
    output logic [WSUM_W-1:0]      wsum
);
    logic [WIDTH-1:0]  flips;
    logic [WSUM_W-1:0] acc;

    always_comb begin
        flips = cur ^ nxt;
        if (rise_only) begin
            flips = flips & nxt;
        end
        acc = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (flips[i]) begin
                acc = acc + WSUM_W'(wgt_flat[i*WGT_W +: WGT_W]);
            end
        end
        wsum = en ? acc : '0;
    end
endmodule

// File: rtl/tgl_accum.sv
module tgl_accum
    import tgl_pkg::*;
#(
    parameter int SUM_W   = 14,
    parameter int TOTAL_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [SUM_W-1:0]   sum_in,
    output logic [SUM_W-1:0]   cyc_q,
    output logic [TOTAL_W-1:0] total_q
);
    localparam logic [TOTAL_W-1:0] TOT_MAX = '1;

    acc_state_e         state_q, state_d;
    logic [TOTAL_W:0]   wide;
    logic               reach;

    assign wide  = {1'b0, total_q} + (TOTAL_W+1)'(sum_in);
    assign reach = (wide >= {1'b0, TOT_MAX});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_RUN:  if (!clr && reach) state_d = ACC_FULL;
            ACC_FULL: if (clr)           state_d = ACC_RUN;
            default:                     state_d = ACC_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            total_q <= '0;
        end else if (clr) begin
            cyc_q   <= '0;
            total_q <= '0;
        end else begin
            cyc_q <= sum_in;
            unique case (state_q)
                ACC_RUN:  total_q <= reach ? TOT_MAX : wide[TOTAL_W-1:0];
                ACC_FULL: total_q <= TOT_MAX;
                default:  total_q <= TOT_MAX;
            endcase
        end
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cyc_q == '0 && total_q == '0));

    // R8
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (total_q >= $past(total_q)));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_FULL) |-> (total_q == TOT_MAX));

    // R7
    cyc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cyc_q == $past(sum_in)));
endmodule

// File: rtl/tgl_activity_meter.sv
module tgl_activity_meter
    import tgl_pkg::*;
#(
    parameter int NWORDS  = 4,
    parameter int WIDTH   = 16,
    parameter int WGT_W   = 8,
    parameter int TOTAL_W = 32,
    localparam int IDX_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int SUM_W  = $clog2(NWORDS*WIDTH*((1 << WGT_W) - 1) + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     up_mode,
    input  logic [NWORDS-1:0]        incl_mask,
    input  logic [NWORDS-1:0]        upd_vld,
    input  logic [NWORDS*WIDTH-1:0]  cur_bus,
    input  logic [NWORDS*WIDTH-1:0]  nxt_bus,
    input  logic                     wgt_we,
    input  logic [IDX_W-1:0]         wgt_idx,
    input  logic [WGT_W-1:0]         wgt_val,
    output logic [SUM_W-1:0]         cyc_act,
    output logic [TOTAL_W-1:0]       run_total
);
    localparam int WSUM_W = $clog2(WIDTH*((1 << WGT_W) - 1) + 1);

    edge_mode_e                 mode;
    logic [WIDTH*WGT_W-1:0]     wgt_flat;
    logic [NWORDS-1:0]          word_en;
    logic [NWORDS*WSUM_W-1:0]   wsums;
    logic [SUM_W-1:0]           cyc_sum;

    assign mode = edge_mode_e'(up_mode);

    tgl_weight_bank #(
        .WIDTH (WIDTH),
        .WGT_W (WGT_W),
        .IDX_W (IDX_W)
    ) u_wbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wgt_we),
        .wr_idx   (wgt_idx),
        .wr_val   (wgt_val),
        .wgt_flat (wgt_flat)
    );

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign word_en[w] = upd_vld[w] && ((incl_mask == '0) || incl_mask[w]);

        tgl_word_sum #(
            .WIDTH  (WIDTH),
            .WGT_W  (WGT_W),
            .WSUM_W (WSUM_W)
        ) u_wsum (
            .cur       (cur_bus[w*WIDTH +: WIDTH]),
            .nxt       (nxt_bus[w*WIDTH +: WIDTH]),
            .rise_only (mode == EDGE_RISE),
            .en        (word_en[w]),
            .wgt_flat  (wgt_flat),
            .wsum      (wsums[w*WSUM_W +: WSUM_W])
        );
    end

    always_comb begin
        cyc_sum = '0;
        for (int w = 0; w < NWORDS; w++) begin
            cyc_sum = cyc_sum + SUM_W'(wsums[w*WSUM_W +: WSUM_W]);
        end
    end

    tgl_accum #(
        .SUM_W   (SUM_W),
        .TOTAL_W (TOTAL_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .sum_in  (cyc_sum),
        .cyc_q   (cyc_act),
        .total_q (run_total)
    );

    // R6
    no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && upd_vld == '0) |=> (cyc_act == '0));

    // R5
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && incl_mask != '0 && (incl_mask & upd_vld) == '0) |=> (cyc_act == '0));

    // R2
    rise_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && up_mode && ((~cur_bus & nxt_bus) == '0)) |=> (cyc_act == '0));

    // R1
    still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cur_bus == nxt_bus) |=> (cyc_act == '0));
endmodule

// File: tb/test_tgl_activity_meter.sv
module test_tgl_activity_meter;
    localparam int NW = 4;
    localparam int W  = 16;
    localparam int TW = 16;
    localparam int SW = 14;
    localparam logic [TW-1:0] TMAX = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              up_mode = 1'b0;
    logic [NW-1:0]     incl_mask = '0;
    logic [NW-1:0]     upd_vld = '0;
    logic [NW*W-1:0]   cur_bus = '0;
    logic [NW*W-1:0]   nxt_bus = '0;
    logic              wgt_we = 1'b0;
    logic [3:0]        wgt_idx = '0;
    logic [7:0]        wgt_val = '0;
    logic [SW-1:0]     cyc_act;
    logic [TW-1:0]     run_total;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [SW-1:0] cyc;
        logic [TW-1:0] tot;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            bw[W];
    logic [TW-1:0] mtot = '0;

    always #10 clk = ~clk;

    tgl_activity_meter #(.NWORDS(NW), .WIDTH(W), .WGT_W(8), .TOTAL_W(TW)) i_tgl_activity_meter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .up_mode(up_mode),
        .incl_mask(incl_mask), .upd_vld(upd_vld), .cur_bus(cur_bus), .nxt_bus(nxt_bus),
        .wgt_we(wgt_we), .wgt_idx(wgt_idx), .wgt_val(wgt_val),
        .cyc_act(cyc_act), .run_total(run_total)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic apply(input logic c, input logic m, input logic [NW-1:0] inc,
                         input logic [NW-1:0] vld, input logic [NW*W-1:0] cb,
                         input logic [NW*W-1:0] nb, input logic we,
                         input logic [3:0] idx, input logic [7:0] wv, input string tag);
        exp_t e;
        int s = 0;
        @(negedge clk);
        clr = c; up_mode = m; incl_mask = inc; upd_vld = vld;
        cur_bus = cb; nxt_bus = nb; wgt_we = we; wgt_idx = idx; wgt_val = wv;
        for (int w = 0; w < NW; w++) begin
            if (vld[w] && (inc == '0 || inc[w])) begin
                logic [W-1:0] f;
                f = cb[w*W +: W] ^ nb[w*W +: W];
                if (m) f = f & nb[w*W +: W];
                for (int i = 0; i < W; i++) if (f[i]) s += bw[i];
            end
        end
        if (c) begin
            e.cyc = '0; mtot = '0;
        end else begin
            e.cyc = SW'(s);
            if (int'(mtot) + s >= int'(TMAX)) mtot = TMAX;
            else mtot = TW'(int'(mtot) + s);
        end
        e.tot = mtot;
        e.tag = tag;
        sb.push_back(e);
        if (we) bw[idx] = int'(wv);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " cyc_act"}, 32'(cyc_act), 32'(e.cyc));
            check({e.tag, " run_total"}, 32'(run_total), 32'(e.tot));
        end
    end

    initial begin
        #5_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < W; i++) bw[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4 reset state
        check("R4 reset cyc_act", 32'(cyc_act), 0);
        check("R4 reset run_total", 32'(run_total), 0);
        // R4 default weights of 1, R1 any-edge, R7 latency
        apply(0, 0, 4'b0000, 4'b0001, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0F0F, 0, 0, 0, "R4_R1");
        // R1 several words
        apply(0, 0, 4'b0000, 4'b1111, 64'h1234_FFFF_0000_AAAA, 64'h4321_0000_0000_5555, 0, 0, 0, "R1_R7");
        // R2 rising only, same pattern
        apply(0, 1, 4'b0000, 4'b1111, 64'h1234_FFFF_0000_AAAA, 64'h4321_0000_0000_5555, 0, 0, 0, "R2");
        // R2 only falling bits -> zero
        apply(0, 1, 4'b0000, 4'b1111, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 0, 0, 0, "R2_fall");
        // R6 strobes
        apply(0, 0, 4'b0000, 4'b0100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 0, 0, 0, "R6");
        apply(0, 0, 4'b0000, 4'b0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 0, 0, 0, "R6_none");
        // R5 include mask
        apply(0, 0, 4'b0101, 4'b1111, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00FF_0F00_0000, 0, 0, 0, "R5");
        apply(0, 0, 4'b1000, 4'b0111, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 0, 0, 0, "R5_off");
        // R3 write weight 3 while bit 3 toggles: old weight used now
        apply(0, 0, 4'b0000, 4'b0001, 64'h0, 64'h0000_0000_0000_0008, 1, 4'd3, 8'd10, "R3_same");
        apply(0, 0, 4'b0000, 4'b0001, 64'h0, 64'h0000_0000_0000_0008, 0, 0, 0, "R3_new");
        apply(0, 0, 4'b0000, 4'b0011, 64'h0, 64'h0000_0000_0018_0009, 1, 4'd0, 8'd200, "R3_mix");
        // R9 clear with activity
        apply(1, 0, 4'b0000, 4'b1111, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R9");
        // R9 weights kept after clear
        apply(0, 0, 4'b0000, 4'b0001, 64'h0, 64'h0000_0000_0000_0009, 0, 0, 0, "R9_keep");
        // R8 saturation: all weights to max, no activity while loading
        for (int i = 0; i < W; i++)
            apply(0, 0, 4'b0000, 4'b0000, 64'h0, 64'h0, 1, 4'(i), 8'd255, "R3_load");
        apply(1, 0, 4'b0000, 4'b0000, 64'h0, 64'h0, 0, 0, 0, "R9_pre");
        for (int k = 0; k < 6; k++)
            apply(0, 0, 4'b0000, 4'b1111, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R8");
        apply(0, 1, 4'b0000, 4'b0001, 64'h0, 64'h0000_0000_0000_0001, 0, 0, 0, "R8_hold");
        // R9 clear out of saturation, then restart from zero
        apply(1, 0, 4'b0000, 4'b1111, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R9_full");
        apply(0, 0, 4'b0000, 4'b0001, 64'h0, 64'h0000_0000_0000_0003, 0, 0, 0, "R9_restart");
        apply(0, 0, 4'b0000, 4'b0000, 64'h0, 64'h0, 0, 0, 0, "R7_idle");
        wait (sb.size() == 0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule